// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers the interrupt causes of a network controller into one cause register and one enable mask. It drives a single level-sensitive interrupt line. Software reaches the two registers through four access points, chosen by a 2-bit selector. The first point reads and clears the cause register, or clears the bits written as one. The second ORs bits into the cause register. The third ORs bits into the mask and reads the mask back. The fourth clears mask bits.

Internal event sources post cause bits through a bit-per-cause pulse vector, one cycle per pulse. A pulse always survives a software clear that happens in the same cycle. Whenever a nonzero cause value is loaded, a summary bit is set in the cause register. Software can therefore test one bit to learn whether anything is pending. The interrupt line is registered, and it follows the cause and mask registers on the same clock edge.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register and the mask register are zero and `irq_o` is low.
- R2: Whenever a cause value is loaded and the loaded value is nonzero, bit SUM_BIT (bit 31 by default) of the cause register is also set, so a nonzero cause always carries that bit.
- R3: A write with `acc_sel` = 1 ORs `acc_wdata` into the cause register.
- R4: `irq_o` is high exactly when the AND of the cause register and the mask register is nonzero, and it changes on the same clock edge as the register update that causes the change.
- R5: A read with `acc_sel` = 0 returns the current cause value on `acc_rdata` in the same cycle, and the cause register is zero after that edge when no event arrives.
- R6: A write with `acc_sel` = 0 clears exactly the cause bits written as one and keeps the others.
- R7: A write with `acc_sel` = 2 ORs `acc_wdata` into the mask. A write with `acc_sel` = 3 clears the mask bits written as one.
- R8: A bit pulsed on `hw_event_i` is set in the cause register after that edge, even if a read-clear or a write-one-to-clear in the same cycle targets that bit.
- R9: A read with `acc_sel` = 2 returns the mask. A read with `acc_sel` = 1 or 3 returns zero, and such a read changes neither register.
- R10: Event pulses with no access in progress are ORed into the cause register. The summary bit is set with them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 cause read-clear / W1C, 1 cause set, 2 mask set, 3 mask clear |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid in the access cycle |
| hw_event_i | input | DATA_W | One-cycle cause pulses from event sources |
| irq_o | output | 1 | Level interrupt line |

## Verification
Some properties are checked on every cycle. The line always matches the AND of the two registers, and a nonzero cause always carries the summary bit. Pulsed events are never lost. After a read-clear, a set write or a mask write, the targeted bits have the expected state. The directed scenarios cover what needs exact values. These include read data returned before the clear, the write-one-to-clear that removes only the summary bit and sees it come back, and readback through each access point. They also cover the ordering of an event that collides with a clear.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_CSET  = 2'd1,
        SEL_MSET  = 2'd2,
        SEL_MCLR  = 2'd3
    } acc_sel_e;

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int DATA_W  = 32,
    parameter int SUM_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all_i,
    input  logic              w1c_i,
    input  logic              set_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] event_i,
    output logic [DATA_W-1:0] cause_d_o,
    output logic [DATA_W-1:0] cause_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cause;
    } cause_st_t;

    cause_st_t st_d, st_q;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] merged;
    logic              load;

    always_comb begin
        st_d   = st_q;
        base   = st_q.cause;
        if (clr_all_i) begin
            base = '0;
        end else if (w1c_i) begin
            base = st_q.cause & ~wdata_i;
        end else if (set_i) begin
            base = st_q.cause | wdata_i;
        end
        merged = base | event_i;
        load   = clr_all_i | w1c_i | set_i | (|event_i);
        if (load) begin
            st_d.cause = merged;
            if (|merged) begin
                st_d.cause[SUM_BIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_d_o = st_d.cause;
    assign cause_q_o = st_q.cause;

    assert_summary_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.cause) |-> st_q.cause[SUM_BIT]);

    assert_set_ors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_all_i && !w1c_i) |=> ((st_q.cause & $past(wdata_i)) == $past(wdata_i)));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_i && event_i == '0) |=> (st_q.cause == '0));

    assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((st_q.cause & $past(event_i)) == $past(event_i)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_d_o,
    output logic [DATA_W-1:0] mask_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.mask = st_q.mask | wdata_i;
        end else if (clr_i) begin
            st_d.mask = st_q.mask & ~wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_d_o = st_d.mask;
    assign mask_q_o = st_q.mask;

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((st_q.mask & $past(wdata_i)) == $past(wdata_i)));

    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> ((st_q.mask & $past(wdata_i)) == '0));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int DATA_W  = 32,
    parameter bit IRQ_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cause_d_i,
    input  logic [DATA_W-1:0] mask_d_i,
    input  logic [DATA_W-1:0] cause_q_i,
    input  logic [DATA_W-1:0] mask_q_i,
    output logic              irq_o
);

    generate
        if (IRQ_REG) begin : g_reg
            typedef struct packed {
                logic irq;
            } line_st_t;

            line_st_t st_d, st_q;

            always_comb begin
                st_d.irq = |(cause_d_i & mask_d_i);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign irq_o = st_q.irq;
        end else begin : g_comb
            assign irq_o = |(cause_q_i & mask_q_i);
        end
    endgenerate

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
    parameter int DATA_W  = 32,
    parameter int SUM_BIT = DATA_W - 1,
    parameter bit IRQ_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [DATA_W-1:0] hw_event_i,
    output logic              irq_o
);

    import irq_ctl_pkg::*;

    acc_sel_e          sel;
    logic              rd_en, wr_en;
    logic              cause_rdclr, cause_w1c, cause_set;
    logic              mask_set, mask_clr;
    logic [DATA_W-1:0] cause_d, cause_q, mask_d, mask_q;

    always_comb begin
        sel         = acc_sel_e'(acc_sel);
        rd_en       = acc_valid & ~acc_write;
        wr_en       = acc_valid &  acc_write;
        cause_rdclr = rd_en & (sel == SEL_CAUSE);
        cause_w1c   = wr_en & (sel == SEL_CAUSE);
        cause_set   = wr_en & (sel == SEL_CSET);
        mask_set    = wr_en & (sel == SEL_MSET);
        mask_clr    = wr_en & (sel == SEL_MCLR);
    end

    always_comb begin
        acc_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CAUSE: acc_rdata = cause_q;
                SEL_MSET:  acc_rdata = mask_q;
                default:   acc_rdata = '0;
            endcase
        end
    end

    irq_cause_reg #(.DATA_W(DATA_W), .SUM_BIT(SUM_BIT)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all_i (cause_rdclr),
        .w1c_i     (cause_w1c),
        .set_i     (cause_set),
        .wdata_i   (acc_wdata),
        .event_i   (hw_event_i),
        .cause_d_o (cause_d),
        .cause_q_o (cause_q)
    );

    irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (mask_set),
        .clr_i    (mask_clr),
        .wdata_i  (acc_wdata),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    irq_line_gen #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_d_i (cause_d),
        .mask_d_i  (mask_d),
        .cause_q_i (cause_q),
        .mask_q_i  (mask_q),
        .irq_o     (irq_o)
    );

    assert_irq_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(cause_q & mask_q)));

endmodule

// File: tb/irq_cause_ctrl_bench.sv
module irq_cause_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [31:0] hw_event_i = '0;
    logic        irq_o;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask  = '0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    irq_cause_ctrl u_irq_cause_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_sel    (acc_sel),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .hw_event_i (hw_event_i),
        .irq_o      (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic w, input logic [1:0] s,
                         input logic [31:0] wd, input logic [31:0] ev);
        logic [31:0] base = m_cause;
        logic        upd  = 1'b0;
        logic [31:0] nxt;
        if (v) begin
            if (s == 2'd0 && !w) begin base = '0; upd = 1'b1; end
            if (s == 2'd0 &&  w) begin base = base & ~wd; upd = 1'b1; end
            if (s == 2'd1 &&  w) begin base = base | wd; upd = 1'b1; end
            if (s == 2'd2 &&  w) m_mask = m_mask | wd;
            if (s == 2'd3 &&  w) m_mask = m_mask & ~wd;
        end
        if (ev != '0) upd = 1'b1;
        nxt = base | ev;
        if (upd) begin
            if (nxt != '0) nxt[31] = 1'b1;
            m_cause = nxt;
        end
    endtask

    task automatic access(input logic v, input logic w, input logic [1:0] s,
                          input logic [31:0] wd, input logic [31:0] ev,
                          output logic [31:0] r);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_sel = s; acc_wdata = wd; hw_event_i = ev;
        #2 r = acc_rdata;
        @(posedge clk);
        model(v, w, s, wd, ev);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; hw_event_i = '0;
    endtask

    task automatic chk_irq(input string req);
        chk(req, {31'd0, irq_o}, {31'd0, |(m_cause & m_mask)});
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        access(1, 0, 2'd2, 0, 0, rd); chk("R1 mask after reset", rd, 32'd0);
        access(1, 0, 2'd0, 0, 0, rd); chk("R1 cause after reset", rd, 32'd0);
    endtask

    task automatic t_set_summary;
        access(1, 1, 2'd1, 32'h5, 0, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R2 summary with set", rd, 32'h8000_0005);
        access(1, 1, 2'd1, 32'h3, 0, rd);
        access(1, 1, 2'd1, 32'h10, 0, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R3 set ORs", rd, 32'h8000_0013);
        access(1, 0, 2'd0, 0, 0, rd); chk("R5 cleared after read", rd, 32'h0);
    endtask

    task automatic t_w1c;
        access(1, 1, 2'd1, 32'hF, 0, rd);
        access(1, 1, 2'd0, 32'h3, 0, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R6 w1c partial", rd, 32'h8000_000C);
        access(1, 1, 2'd1, 32'hF, 0, rd);
        access(1, 1, 2'd0, 32'h8000_000F, 0, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R6 w1c all", rd, 32'h0);
        access(1, 1, 2'd1, 32'h1, 0, rd);
        access(1, 1, 2'd0, 32'h8000_0000, 0, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R2 summary reloaded after w1c", rd, 32'h8000_0001);
    endtask

    task automatic t_mask_irq;
        access(1, 1, 2'd2, 32'h6, 0, rd);
        access(1, 0, 2'd2, 0, 0, rd); chk("R7 mask set", rd, 32'h6);
        access(1, 1, 2'd1, 32'h1, 0, rd); chk_irq("R4 masked cause");
        chk("R4 irq low", {31'd0, irq_o}, 32'd0);
        access(1, 1, 2'd1, 32'h4, 0, rd); chk("R4 irq high", {31'd0, irq_o}, 32'd1);
        access(1, 1, 2'd3, 32'h4, 0, rd); chk("R4 irq low after mask clear", {31'd0, irq_o}, 32'd0);
        access(1, 1, 2'd2, 32'h1, 0, rd); chk("R4 irq high after mask set", {31'd0, irq_o}, 32'd1);
        access(1, 0, 2'd0, 0, 0, rd); chk("R5 read value", rd, 32'h8000_0005);
        chk("R5 irq low after read", {31'd0, irq_o}, 32'd0);
        access(1, 1, 2'd3, 32'hFFFF_FFFF, 0, rd);
        access(1, 0, 2'd2, 0, 0, rd); chk("R7 mask clear all", rd, 32'h0);
    endtask

    task automatic t_event_priority;
        access(1, 1, 2'd1, 32'h3, 0, rd);
        access(1, 0, 2'd0, 0, 32'h100, rd); chk("R8 read returns old value", rd, 32'h8000_0003);
        access(1, 0, 2'd0, 0, 0, rd); chk("R8 event kept over read clear", rd, 32'h8000_0100);
        access(1, 1, 2'd1, 32'h100, 0, rd);
        access(1, 1, 2'd0, 32'h100, 32'h100, rd);
        access(1, 0, 2'd0, 0, 0, rd); chk("R8 event kept over w1c", rd, 32'h8000_0100);
    endtask

    task automatic t_port_reads;
        access(1, 1, 2'd2, 32'hA5, 0, rd);
        access(1, 1, 2'd1, 32'h2, 0, rd);
        access(1, 0, 2'd1, 0, 0, rd); chk("R9 cause-set port reads zero", rd, 32'h0);
        access(1, 0, 2'd3, 0, 0, rd); chk("R9 mask-clear port reads zero", rd, 32'h0);
        access(1, 0, 2'd2, 0, 0, rd); chk("R9 mask readback", rd, 32'hA5);
        access(1, 0, 2'd0, 0, 0, rd); chk("R9 cause untouched by reads", rd, 32'h8000_0002);
        access(1, 1, 2'd3, 32'hFF, 0, rd);
    endtask

    task automatic t_events_idle;
        access(1, 1, 2'd2, 32'h40, 0, rd);
        access(0, 0, 2'd0, 0, 32'h40, rd); chk("R10 idle event raises irq", {31'd0, irq_o}, 32'd1);
        access(0, 0, 2'd0, 0, 32'h8, rd); chk_irq("R10 second event");
        access(1, 0, 2'd0, 0, 0, rd); chk("R10 idle events collected", rd, 32'h8000_0048);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_set_summary();
        t_w1c();
        t_mask_irq();
        t_event_priority();
        t_port_reads();
        t_events_idle();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule